// File: doc/BRIEF.md
# Dual Serial Game-Pad Poller

This block keeps two serial game pads under constant watch. For each pad it drives a latch line and a shift-clock line. It captures the eight button bits the pad returns, one bit per shift clock. When all eight bits of a read are in, it replaces a parallel button register in a single step. The CPU side never takes part in a read. It picks a pad with a select input and reads that pad's held register at any moment. The register always holds the result of the last complete read.

All pad-side timing comes from a clock-enable divider on the poll clock. With a poll clock of about 5 MHz and the default divider, each latch or shift phase lasts roughly 6 µs. The pad data lines are active-low and are not synchronous to the poll clock. Each one passes through a two-flop synchroniser before it is sampled, and its polarity is inverted so that a 1 in the register means the button is pressed.

The read port is a plain register read. It has no handshake and no back-pressure. Any read returns a full snapshot, and the value is never held back or stalled.

Top module: `pad_poller`

## Requirements
- R1: While reset is asserted and after it is released, until the first read completes, `rd_data` is 0 for both pads and all latch and shift-clock pins are low.
- R2: Each read begins with a latch pulse lasting exactly LATCH_TICKS×TICK_DIV clocks. It is followed by exactly 8 shift-clock pulses, each high for TICK_DIV clocks and preceded by a low phase of TICK_DIV clocks. Latch and shift clock of one pad are never high together.
- R3: Reads repeat without any request, with a period of (LATCH_TICKS+16)×TICK_DIV clocks from one latch rise to the next.
- R4: The k-th serial bit of a read (k = 0..7) lands in register bit k. The order is A=bit 0, B=bit 1, Select=bit 2, Start=bit 3, Up=bit 4, Down=bit 5, Left=bit 6, Right=bit 7. Bit 0 is taken from the line before the first shift-clock rise.
- R5: The pad data line is active-low. A low level on the line is stored as 1 (pressed), and a high level is stored as 0.
- R6: The two pads are independent. `rd_sel`=0 returns pad 0's register and `rd_sel`=1 returns pad 1's register, and neither pad's buttons affect the other's register.
- R7: A register changes only at the end of a complete read, in the same cycle as the next latch rise. A read during a button change returns either the old full value or the new full value, never a mix of the two.
- R8: The latch and shift-clock pins change only in the cycle after a divider tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Poll clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pad_latch | output | NUM_PORTS | Latch line per pad, high to load the pad's buttons |
| pad_sclk | output | NUM_PORTS | Shift clock per pad; the pad advances on its rising edge |
| pad_data_n | input | NUM_PORTS | Serial data per pad, active-low, asynchronous |
| rd_sel | input | SEL_W | Pad select for the read port |
| rd_data | output | 8 | Held button register of the selected pad |

## Verification
The bench builds the block with TICK_DIV=4 and LATCH_TICKS=2, so one complete read takes 72 clocks. At that rate dozens of reads fit in a short run. Button sets are changed in the middle of reads, and the pin timing can be measured cycle by cycle against the formulas. Behavioural models of both pads sit on the pins. Random and directed button patterns then exercise bit order, polarity, independence of the pads, and the single-step update.

// File: rtl/pad_poll_pkg.sv
package pad_poll_pkg;
  localparam int BTN_W = 8;
  typedef logic [BTN_W-1:0] btn_vec_t;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_LATCH = 2'd1,
    SEQ_LOW   = 2'd2,
    SEQ_HIGH  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/pad_tick_gen.sv
module pad_tick_gen #(
  parameter int DIV = 30
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == LAST);
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pad_sync.sv
module pad_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)      stg_q[s] <= '1;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pad_seq.sv
module pad_seq
  import pad_poll_pkg::*;
#(
  parameter int LATCH_TICKS = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_i,
  input  logic     din_n_i,
  output logic     latch_o,
  output logic     sclk_o,
  output btn_vec_t state_o
);
  localparam int LW = (LATCH_TICKS > 1) ? $clog2(LATCH_TICKS) : 1;
  localparam int BW = $clog2(BTN_W);
  localparam logic [LW-1:0] L_LAST = LW'(LATCH_TICKS - 1);
  localparam logic [BW-1:0] B_LAST = BW'(BTN_W - 1);

  seq_st_e       st_q;
  logic [LW-1:0] lcnt_q;
  logic [BW-1:0] bit_q;
  btn_vec_t      shr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      lcnt_q  <= '0;
      bit_q   <= '0;
      shr_q   <= '0;
      state_o <= '0;
    end else if (tick_i) begin
      unique case (st_q)
        SEQ_IDLE: begin
          st_q   <= SEQ_LATCH;
          lcnt_q <= '0;
        end
        SEQ_LATCH: begin
          if (lcnt_q == L_LAST) begin
            st_q  <= SEQ_LOW;
            bit_q <= '0;
          end else begin
            lcnt_q <= lcnt_q + 1'b1;
          end
        end
        SEQ_LOW: begin
          shr_q[bit_q] <= ~din_n_i;
          st_q         <= SEQ_HIGH;
        end
        SEQ_HIGH: begin
          if (bit_q == B_LAST) begin
            state_o <= shr_q;
            st_q    <= SEQ_LATCH;
            lcnt_q  <= '0;
          end else begin
            bit_q <= bit_q + 1'b1;
            st_q  <= SEQ_LOW;
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign latch_o = (st_q == SEQ_LATCH);
  assign sclk_o  = (st_q == SEQ_HIGH);
endmodule

// File: rtl/pad_poller.sv
module pad_poller
  import pad_poll_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int TICK_DIV    = 30,
  parameter int LATCH_TICKS = 2,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [NUM_PORTS-1:0] pad_latch,
  output logic [NUM_PORTS-1:0] pad_sclk,
  input  logic [NUM_PORTS-1:0] pad_data_n,
  input  logic [SEL_W-1:0]     rd_sel,
  output logic [BTN_W-1:0]     rd_data
);
  logic                 tick;
  logic [NUM_PORTS-1:0] data_n_s;
  btn_vec_t             held [NUM_PORTS];

  pad_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  pad_sync #(.W(NUM_PORTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pad_data_n),
    .q_o   (data_n_s)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pad_seq #(.LATCH_TICKS(LATCH_TICKS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick),
      .din_n_i (data_n_s[p]),
      .latch_o (pad_latch[p]),
      .sclk_o  (pad_sclk[p]),
      .state_o (held[p])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (SEL_W'(p) == rd_sel) rd_data = held[p];
    end
  end
endmodule

// File: rtl/pad_poller_chk.sv
module pad_poller_chk #(
  parameter int NUM_PORTS = 2,
  parameter int SEL_W     = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic [NUM_PORTS-1:0] pad_latch,
  input logic [NUM_PORTS-1:0] pad_sclk,
  input logic [SEL_W-1:0]     rd_sel,
  input logic [7:0]           rd_data
);
  // R2
  latch_sclk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_latch & pad_sclk) == '0);

  // R8
  pins_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pad_latch) || !$stable(pad_sclk)) |-> $past(tick));

  // R7
  atomic_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rd_data) && $stable(rd_sel)) |-> $rose(pad_latch[rd_sel]));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
    // R2
    low_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pad_latch[p]) |-> !pad_sclk[p]);
    // R2
    sclk_rise_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pad_sclk[p]) |-> $past(!pad_latch[p]));
  end
endmodule

bind pad_poller pad_poller_chk #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .pad_latch (pad_latch),
  .pad_sclk  (pad_sclk),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data)
);

// File: tb/pad_poller_tb.sv
module pad_poller_tb;
  localparam int D     = 4;
  localparam int L     = 2;
  localparam int FRAME = (L + 16) * D;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pad_latch, pad_sclk, pad_data_n;
  logic [0:0] rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] btn [2];
  logic [7:0] sr  [2];
  logic [1:0] sclk_q = 2'b00;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pad_poller #(.NUM_PORTS(2), .TICK_DIV(D), .LATCH_TICKS(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .pad_latch(pad_latch), .pad_sclk(pad_sclk),
    .pad_data_n(pad_data_n), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  // pad models: load while latched, shift on shift-clock rise, active-low out
  initial begin
    for (int p = 0; p < 2; p++) begin sr[p] = 8'h00; btn[p] = 8'h00; end
  end
  always @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (pad_latch[p])                   sr[p] <= btn[p];
      else if (pad_sclk[p] && !sclk_q[p]) sr[p] <= {1'b0, sr[p][7:1]};
    end
    sclk_q <= pad_sclk;
  end
  assign pad_data_n = {~sr[1][0], ~sr[0][0]};

  function automatic logic [7:0] pack(input bit a, b, sel, st, up, dn, lf, rt);
    return {rt, lf, dn, up, st, sel, b, a};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_port(input int p, output logic [7:0] v);
    @(negedge clk);
    rd_sel = 1'(p);
    #1 v = rd_data;
  endtask

  task automatic settle();
    repeat (3 * FRAME) @(negedge clk);
  endtask

  task automatic apply_check(input logic [7:0] b0, input logic [7:0] b1, input string req);
    logic [7:0] v;
    btn[0] = b0; btn[1] = b1;
    settle();
    read_port(0, v); chk(req, v, b0);
    read_port(1, v); chk(req, v, b1);
  endtask

  task automatic measure(input int p);
    int hi = 0, rises = 0, per = 0, wmin = 1000, wmax = 0, w = 0, both = 0;
    logic pl, ps;
    pl = 1'b1;
    do begin @(negedge clk); pl = pad_latch[p]; end while (pl);
    do begin @(negedge clk); end while (!pad_latch[p]);
    while (pad_latch[p]) begin hi++; per++; @(negedge clk); end
    ps = 1'b0;
    while (!pad_latch[p]) begin
      per++;
      if (pad_sclk[p]) w++;
      if (pad_sclk[p] && !ps) rises++;
      if (!pad_sclk[p] && ps) begin
        if (w < wmin) wmin = w;
        if (w > wmax) wmax = w;
        w = 0;
      end
      if (pad_sclk[p] && pad_latch[p]) both++;
      ps = pad_sclk[p];
      @(negedge clk);
    end
    chk("R2 latch width", hi, L * D);
    chk("R2 sclk pulses", rises, 8);
    chk("R2 sclk high min", wmin, D);
    chk("R2 sclk high max", wmax, D);
    chk("R2 overlap", both, 0);
    chk("R3 period", per, FRAME);
  endtask

  initial begin
    logic [7:0] v, oldv, newv;
    int mixed;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    // R1 reset state
    read_port(0, v); chk("R1 rd0 in reset", v, 0);
    chk("R1 pins in reset", {pad_latch, pad_sclk}, 0);
    @(negedge clk); rst_n = 1'b1;
    btn[0] = 8'hA5; btn[1] = 8'h3C;
    repeat (FRAME / 2) @(negedge clk);
    read_port(0, v); chk("R1 rd0 before first read", v, 0);
    read_port(1, v); chk("R1 rd1 before first read", v, 0);
    // R2 R3 pin timing on both pads
    measure(0);
    measure(1);
    // R4 R5 directed bit order
    apply_check(pack(1,0,0,0,0,0,0,0), 8'h00, "R4 A only bit0");
    apply_check(pack(0,0,0,0,0,0,0,1), 8'h00, "R4 Right only bit7");
    apply_check(pack(0,0,1,0,0,0,0,0), pack(0,0,0,1,0,0,0,0), "R4 Select/Start");
    apply_check(pack(0,0,0,0,1,0,1,0), pack(0,0,0,0,0,1,0,0), "R4 Up/Left/Down");
    apply_check(8'hFF, 8'h00, "R5 all pressed");
    apply_check(8'h00, 8'hFF, "R6 pads independent");
    // R6 R4 random patterns
    for (int i = 0; i < 16; i++) begin
      apply_check(8'($urandom), 8'($urandom), "R6 random");
    end
    // R7 atomic update during change
    for (int t = 0; t < 3; t++) begin
      oldv = 8'($urandom); newv = ~oldv;
      btn[0] = oldv; settle();
      rd_sel = 1'b0;
      repeat (t * 13 + 5) @(negedge clk);
      btn[0] = newv;
      mixed = 0;
      repeat (3 * FRAME) begin
        @(negedge clk);
        if (rd_data !== oldv && rd_data !== newv) mixed++;
      end
      chk("R7 no mixed value", mixed, 0);
      chk("R7 final value", rd_data, newv);
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule